// File: doc/BRIEF.md
# Conversion Sequencer with Result Stack

This block sits between the serial target of a sampling converter and the successive-approximation core. When the serial target decodes a conversion command it pulses a trigger. The block then starts conversions on the core, one at a time, with a start pulse. It waits for each done pulse and captures the 12-bit result. In the slow bus modes (standard and fast) one trigger runs four conversions back to back. The block pushes each result onto a four-entry last-in-first-out store and raises ready once the fourth result is stored. In high-speed mode one trigger runs a single conversion, and ready stays low until that conversion has finished. The serial target can hold the bus clock low on this ready signal.

While the serial target reports a read in progress, the block powers the converter down. Each pop request takes one word from the store. A pop against an empty store returns zero and sets a sticky overflow flag. This covers a fifth read in a slow-mode sequence and a second read in high-speed mode. The converter clock enable turns on at a trigger. It turns off only when a read begins, so it stays on if no read follows the command.

Top module: `conv_seq_stack`

## Requirements
- R1: After an accepted trigger with `hs_mode` low, exactly four `adc_start` pulses are issued, one per conversion, and never while `adc_busy` is high.
- R2: With `hs_mode` low, `ready` goes high only after the fourth `adc_done` has been received. `ready` is low in the cycle after a trigger is accepted.
- R3: A pop accepted while `ready` is high updates `rd_data` in the next cycle. The value is the most recently stored word not yet popped, so the words of a burst come out newest first.
- R4: A pop accepted with the store empty sets `rd_data` to zero and sets `ovf`. `ovf` stays set until the next accepted trigger.
- R5: After an accepted trigger with `hs_mode` high, exactly one `adc_start` pulse is issued, and `ready` stays low until its `adc_done` has been received.
- R6: In high-speed mode the first pop returns the single converted word. The second and any later pops return zero and set `ovf`.
- R7: `adc_pd` equals the value of `rd_active` one cycle earlier, so the converter is powered down while a read is in progress.
- R8: `clk_en` rises in the cycle after an accepted trigger. It stays high until `rd_active` is seen and falls in the cycle after that.
- R9: A trigger arriving while conversions are in progress (`ready` low after an accepted trigger) is ignored. It causes no extra conversion and does not restart the count.
- R10: An accepted trigger empties the store, clears `ovf` and sets `rd_data` to zero, so pops after the new burst return only the new results.
- R11: A pop while `ready` is low is ignored: `rd_data` and `ovf` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 1 | Conversion command pulse from the serial target |
| hs_mode | input | 1 | 1 = high-speed bus mode, 0 = standard/fast mode |
| rd_active | input | 1 | Read of results in progress |
| rd_pop | input | 1 | Request for the next result word |
| rd_data | output | 12 | Word returned by the last accepted pop |
| ready | output | 1 | All conversions of the current burst are stored |
| ovf | output | 1 | Sticky flag: a pop found the store empty |
| adc_start | output | 1 | One-cycle start pulse to the converter core |
| adc_busy | input | 1 | Converter core is converting |
| adc_done | input | 1 | One-cycle pulse: conversion result valid |
| adc_data | input | 12 | Conversion result from the core |
| adc_pd | output | 1 | Converter power-down request |
| clk_en | output | 1 | Converter internal clock enable |

## Verification
On every cycle, the assertions check the following. Starts never collide with a busy core. Ready drops when a trigger is accepted. The overflow flag only rises on an accepted pop and never falls without a trigger. A pop while not ready leaves the flag alone. Power-down tracks the read window and the clock enable follows its trigger/read rule. The bench scenarios are needed for the rest: the conversion count per burst in each mode, the newest-first order of the returned words, the zero returned on an empty store, and the proof that a trigger in mid-burst adds no conversion and that a new burst discards old data.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_WAIT  = 2'd2,
        SEQ_READY = 2'd3
    } seq_state_e;
endpackage

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl
    import conv_seq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic hs_mode,
    input  logic rd_active,
    input  logic adc_busy,
    input  logic adc_done,
    output logic adc_start,
    output logic push,
    output logic clear,
    output logic ready,
    output logic adc_pd,
    output logic clk_en
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        seq_state_e    state;
        logic [CW-1:0] cnt;
        logic [CW-1:0] goal;
        logic          clk_en;
        logic          pd;
    } ctrl_regs_t;

    ctrl_regs_t r_q, r_d;

    always_comb begin
        r_d       = r_q;
        adc_start = 1'b0;
        push      = 1'b0;
        clear     = 1'b0;
        r_d.pd    = rd_active;
        if (rd_active) begin
            r_d.clk_en = 1'b0;
        end
        case (r_q.state)
            SEQ_IDLE, SEQ_READY: begin
                if (trig) begin
                    clear      = 1'b1;
                    r_d.cnt    = '0;
                    r_d.goal   = hs_mode ? CW'(1) : CW'(DEPTH);
                    r_d.state  = SEQ_ISSUE;
                    r_d.clk_en = 1'b1;
                end
            end
            SEQ_ISSUE: begin
                if (!adc_busy) begin
                    adc_start = 1'b1;
                    r_d.state = SEQ_WAIT;
                end
            end
            SEQ_WAIT: begin
                if (adc_done) begin
                    push    = 1'b1;
                    r_d.cnt = r_q.cnt + CW'(1);
                    if (r_q.cnt + CW'(1) == r_q.goal) begin
                        r_d.state = SEQ_READY;
                    end else begin
                        r_d.state = SEQ_ISSUE;
                    end
                end
            end
            default: r_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: SEQ_IDLE, cnt: '0, goal: '0, clk_en: 1'b0, pd: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ready  = (r_q.state == SEQ_READY);
    assign adc_pd = r_q.pd;
    assign clk_en = r_q.clk_en;
endmodule

// File: rtl/conv_seq_store.sv
module conv_seq_store #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic              ovf
);
    localparam int PW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PW-1:0]                ptr;
        logic [DATA_W-1:0]            dout;
        logic                         ovf;
    } store_regs_t;

    store_regs_t s_q, s_d;
    logic [PW-1:0] top_idx;

    assign top_idx = s_q.ptr - PW'(1);

    always_comb begin
        s_d = s_q;
        if (clear) begin
            s_d.ptr  = '0;
            s_d.ovf  = 1'b0;
            s_d.dout = '0;
        end else if (push) begin
            s_d.mem[s_q.ptr[IW-1:0]] = push_data;
            s_d.ptr                  = s_q.ptr + PW'(1);
        end else if (pop) begin
            if (s_q.ptr == '0) begin
                s_d.dout = '0;
                s_d.ovf  = 1'b1;
            end else begin
                s_d.dout = s_q.mem[top_idx[IW-1:0]];
                s_d.ptr  = top_idx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dout = s_q.dout;
    assign ovf  = s_q.ovf;
endmodule

// File: rtl/conv_seq_stack.sv
module conv_seq_stack #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic              hs_mode,
    input  logic              rd_active,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] rd_data,
    output logic              ready,
    output logic              ovf,
    output logic              adc_start,
    input  logic              adc_busy,
    input  logic              adc_done,
    input  logic [DATA_W-1:0] adc_data,
    output logic              adc_pd,
    output logic              clk_en
);
    logic push, clear, pop_ok;

    assign pop_ok = rd_pop & ready;

    conv_seq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig),
        .hs_mode   (hs_mode),
        .rd_active (rd_active),
        .adc_busy  (adc_busy),
        .adc_done  (adc_done),
        .adc_start (adc_start),
        .push      (push),
        .clear     (clear),
        .ready     (ready),
        .adc_pd    (adc_pd),
        .clk_en    (clk_en)
    );

    conv_seq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .push      (push),
        .push_data (adc_data),
        .pop       (pop_ok),
        .dout      (rd_data),
        .ovf       (ovf)
    );
endmodule

// File: rtl/conv_seq_checker.sv
module conv_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic trig,
    input logic rd_active,
    input logic rd_pop,
    input logic ready,
    input logic ovf,
    input logic adc_start,
    input logic adc_busy,
    input logic adc_pd,
    input logic clk_en
);
    assert_start_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> !adc_busy);

    assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && ready) |=> !ready);

    assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !trig) |=> ovf);

    assert_ovf_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(rd_pop && ready));

    assert_pd_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_active |=> adc_pd);

    assert_pd_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_active |=> !adc_pd);

    assert_clk_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active && !trig) |=> !clk_en);

    assert_clk_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && ready) |=> clk_en);

    assert_pop_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pop && !ready && !trig) |=> $stable(ovf));
endmodule

bind conv_seq_stack conv_seq_checker u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig      (trig),
    .rd_active (rd_active),
    .rd_pop    (rd_pop),
    .ready     (ready),
    .ovf       (ovf),
    .adc_start (adc_start),
    .adc_busy  (adc_busy),
    .adc_pd    (adc_pd),
    .clk_en    (clk_en)
);

// File: tb/conv_seq_stack_bench.sv
module conv_seq_stack_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 12;

    typedef struct packed {
        logic       hs;
        logic [3:0] pops;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{hs: 1'b0, pops: 4'd4},
        '{hs: 1'b0, pops: 4'd5},
        '{hs: 1'b1, pops: 4'd1},
        '{hs: 1'b1, pops: 4'd3},
        '{hs: 1'b0, pops: 4'd2},
        '{hs: 1'b0, pops: 4'd6}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig = 1'b0, hs_mode = 1'b0, rd_active = 1'b0, rd_pop = 1'b0;
    logic [W-1:0] rd_data;
    logic ready, ovf, adc_start, adc_pd, clk_en;
    logic adc_busy, adc_done;
    logic [W-1:0] adc_data;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    conv_seq_stack u_conv_seq_stack (
        .clk(clk), .rst_n(rst_n), .trig(trig), .hs_mode(hs_mode),
        .rd_active(rd_active), .rd_pop(rd_pop), .rd_data(rd_data),
        .ready(ready), .ovf(ovf), .adc_start(adc_start),
        .adc_busy(adc_busy), .adc_done(adc_done), .adc_data(adc_data),
        .adc_pd(adc_pd), .clk_en(clk_en)
    );

    // converter core model
    int starts, dones, lat;
    logic [W-1:0] next_val;
    always @(posedge clk) begin
        if (!rst_n) begin
            adc_busy <= 1'b0; adc_done <= 1'b0; adc_data <= '0;
            starts <= 0; dones <= 0; lat <= 0; next_val <= 12'h100;
        end else begin
            adc_done <= 1'b0;
            if (adc_busy) begin
                if (lat == 0) begin
                    adc_busy <= 1'b0; adc_done <= 1'b1;
                    adc_data <= next_val; next_val <= next_val + 12'h011;
                    dones <= dones + 1;
                end else begin
                    lat <= lat - 1;
                end
            end else if (adc_start) begin
                adc_busy <= 1'b1; lat <= 3; starts <= starts + 1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_trig(input logic hs);
        @(negedge clk); hs_mode = hs; trig = 1'b1;
        @(negedge clk); trig = 1'b0;
    endtask

    task automatic do_pop();
        @(negedge clk); rd_pop = 1'b1;
        @(negedge clk); rd_pop = 1'b0;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 300; i++) begin
            if (ready) break;
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int s0, d0;
        logic [W-1:0] base, exp_w;
        int avail;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check("reset ready", ready, 0);
        check("reset R4 ovf", ovf, 0);
        check("reset R3 rd_data", rd_data, 0);
        check("reset R8 clk_en", clk_en, 0);
        check("reset R7 adc_pd", adc_pd, 0);

        // table-driven bursts
        foreach (VECS[v]) begin
            base = next_val; s0 = starts; d0 = dones;
            avail = VECS[v].hs ? 1 : 4;
            pulse_trig(VECS[v].hs);
            check("R2 ready low after trigger", ready, 0);
            check("R8 clk_en on after trigger", clk_en, 1);
            check("R10 ovf cleared by trigger", ovf, 0);
            check("R10 rd_data cleared by trigger", rd_data, 0);
            wait_ready();
            if (VECS[v].hs) begin
                check("R5 one conversion in high-speed", starts - s0, 1);
                check("R5 ready after its done", dones - d0, 1);
            end else begin
                check("R1 four conversions", starts - s0, 4);
                check("R2 ready after fourth done", dones - d0, 4);
            end
            @(negedge clk); rd_active = 1'b1;
            @(negedge clk);
            check("R7 adc_pd during read", adc_pd, 1);
            check("R8 clk_en off during read", clk_en, 0);
            for (int k = 0; k < int'(VECS[v].pops); k++) begin
                do_pop();
                exp_w = (k < avail) ? W'(base + 12'h011 * (avail - 1 - k)) : '0;
                if (VECS[v].hs) check("R6 high-speed pop word", rd_data, exp_w);
                else            check("R3 newest-first pop word", rd_data, exp_w);
                check("R4 ovf after pop", ovf, (k >= avail) ? 1 : 0);
            end
            @(negedge clk); rd_active = 1'b0;
            @(negedge clk);
            check("R7 adc_pd released", adc_pd, 0);
            check("R4 ovf still sticky", ovf, (int'(VECS[v].pops) > avail) ? 1 : 0);
        end

        // R9: trigger mid-burst ignored
        base = next_val; s0 = starts;
        pulse_trig(1'b0);
        repeat (6) @(negedge clk);
        check("R9 still converting", ready, 0);
        pulse_trig(1'b0);
        wait_ready();
        check("R9 no extra conversion", starts - s0, 4);
        repeat (10) @(negedge clk);
        check("R9 no conversion after ready", starts - s0, 4);
        check("R8 clk_en stays on without read", clk_en, 1);
        rd_active = 1'b1;
        do_pop();
        check("R9 first word is fourth result", rd_data, W'(base + 12'h033));
        do_pop(); do_pop(); do_pop();
        check("R9 oldest word last", rd_data, base);
        @(negedge clk); rd_active = 1'b0;

        // R11: pop while not ready ignored
        base = next_val;
        pulse_trig(1'b0);
        do_pop();
        check("R11 rd_data unchanged", rd_data, 0);
        check("R11 ovf unchanged", ovf, 0);
        wait_ready();
        do_pop();
        check("R11 stack intact after ignored pop", rd_data, W'(base + 12'h033));

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule